// File: doc/BRIEF.md
# Aliased Partial-Width Register File

This block holds sixteen 64-bit general-purpose registers and lets each one be reached through several overlapping windows onto the same storage. The windows are the whole register, its low 32 bits, its low 16 bits and its low byte. Four registers also have a second-byte window covering bits 15:8. Registers 0 to 7 serve, in order, as accumulator, counter, data, base, stack pointer, base pointer, source index and destination index. Registers 8 to 15 have no special role.

There are two combinational read ports and one write port that takes effect at the clock edge. Every port takes a register number and a 3-bit view code. Read data comes back right-aligned and zero-extended to 64 bits. A write through a narrow window merges with the bits it does not cover, except for the 32-bit window, which clears the upper half. A second-byte access to a register that has no such window is refused, and so is any unassigned view code. Such a write leaves storage alone and raises a one-cycle reject pulse. Such a read returns zero.

Top module: `rfa_regfile`

## Requirements
- R1: After reset every register reads as zero through the full view.
- R2: A write with view code 0 (full) replaces all 64 bits, and a full-view read returns them.
- R3: A write with view code 2 (bits 15:0) or code 3 (bits 7:0) changes only those bits and keeps the rest of the register.
- R4: A write with view code 1 takes wr_data[31:0] into bits 31:0 and clears bits 63:32.
- R5: For registers 0 to 3, view code 4 reaches bits 15:8. A write stores wr_data[7:0] there and leaves all other bits unchanged. A read returns those bits in data[7:0].
- R6: View code 4 on a register numbered 4 or higher is refused. A write leaves the register unchanged and sets wr_reject high for exactly the one cycle after the write edge. A read returns zero. Accepted writes never raise wr_reject.
- R7: View codes 5, 6 and 7 are refused for every register, with the same write, reject and read behaviour as R6.
- R8: A read through view 1, 2, 3 or 4 returns the selected field right-aligned, with every bit above it zero.
- R9: A read of the register being written in the same cycle returns the old contents. The new contents appear from the cycle after the write edge.
- R10: The two read ports work independently and can read different registers through different views in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears all registers |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Register number to write |
| wr_view | input | 3 | View code for the write (0 full, 1 low 32, 2 low 16, 3 low byte, 4 second byte) |
| wr_data | input | 64 | Write data, right-aligned for narrow views |
| wr_reject | output | 1 | High for one cycle after a refused write |
| ra_idx | input | 4 | Read port A register number |
| ra_view | input | 3 | Read port A view code |
| ra_data | output | 64 | Read port A data, zero-extended |
| rb_idx | input | 4 | Read port B register number |
| rb_view | input | 3 | Read port B view code |
| rb_data | output | 64 | Read port B data, zero-extended |

## Verification
Corrupted storage shows up on a read port in the same cycle it is read, because the reads are combinational. That means a merge error from a partial write is visible one cycle after the write edge. The bench therefore loads each register with a distinctive full-width pattern first, then makes the narrow write, and then reads the full register back. Any bit the merge should have kept but lost shows up directly. A wrong reject decision shows up either as a wr_reject value that is wrong on the very next cycle, or as a changed full-view read of the refused register.

// File: rtl/rfa_pkg.sv
package rfa_pkg;

   // view selector codes shared by the read and write ports
   typedef enum logic [2:0] {
      VIEW_FULL = 3'd0,
      VIEW_LO32 = 3'd1,
      VIEW_LO16 = 3'd2,
      VIEW_LOB  = 3'd3,
      VIEW_HIB  = 3'd4
   } view_e;

   localparam int VIEW_W  = 3;
   localparam int LO32_W  = 32;
   localparam int LO16_W  = 16;
   localparam int BYTE_W  = 8;

   // decoded form of a (register, view) pair
   typedef struct packed {
      logic legal;      // access allowed
      logic hib;        // field sits one byte up
      logic zero_rest;  // write clears bits outside the field
   } view_ctl_t;

endpackage

// File: rtl/rfa_view_decode.sv
module rfa_view_decode
   import rfa_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter int NUM_REGS = 16,
   parameter int HB_REGS  = 4,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic [VIEW_W-1:0] view,
   output view_ctl_t         ctl,
   output logic [XLEN-1:0]   fld_mask
);

   localparam logic [XLEN-1:0] ONES   = '1;
   localparam logic [XLEN-1:0] M_LO32 = ONES >> (XLEN - LO32_W);
   localparam logic [XLEN-1:0] M_LO16 = ONES >> (XLEN - LO16_W);
   localparam logic [XLEN-1:0] M_LOB  = ONES >> (XLEN - BYTE_W);
   localparam logic [XLEN-1:0] M_HIB  = M_LOB << BYTE_W;

   logic idx_in_range;
   logic idx_has_hib;

   generate
      if ((1 << IDX_W) == NUM_REGS) begin : g_pow2
         assign idx_in_range = 1'b1;
      end else begin : g_npow2
         assign idx_in_range = (int'(idx) < NUM_REGS);
      end
   endgenerate

   assign idx_has_hib = (int'(idx) < HB_REGS);

   always_comb begin
      ctl.legal     = idx_in_range;
      ctl.hib       = 1'b0;
      ctl.zero_rest = 1'b0;
      fld_mask      = '0;
      case (view_e'(view))
         VIEW_FULL: begin
            fld_mask      = ONES;
            ctl.zero_rest = 1'b1;
         end
         VIEW_LO32: begin
            fld_mask      = M_LO32;
            ctl.zero_rest = 1'b1;
         end
         VIEW_LO16: fld_mask = M_LO16;
         VIEW_LOB:  fld_mask = M_LOB;
         VIEW_HIB: begin
            if (idx_has_hib) begin
               fld_mask = M_HIB;
               ctl.hib  = 1'b1;
            end else begin
               ctl.legal = 1'b0;
            end
         end
         default: ctl.legal = 1'b0;
      endcase
      if (!ctl.legal) begin
         fld_mask      = '0;
         ctl.hib       = 1'b0;
         ctl.zero_rest = 1'b0;
      end
   end

endmodule

// File: rtl/rfa_read_port.sv
module rfa_read_port
   import rfa_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter int NUM_REGS = 16,
   parameter int HB_REGS  = 4,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic [NUM_REGS-1:0][XLEN-1:0] regs_flat,
   input  logic [IDX_W-1:0]              idx,
   input  logic [VIEW_W-1:0]             view,
   output logic [XLEN-1:0]               data
);

   view_ctl_t         ctl;
   logic [XLEN-1:0]   mask;
   logic [XLEN-1:0]   picked;

   rfa_view_decode #(
      .XLEN     (XLEN),
      .NUM_REGS (NUM_REGS),
      .HB_REGS  (HB_REGS)
   ) u_dec (
      .idx      (idx),
      .view     (view),
      .ctl      (ctl),
      .fld_mask (mask)
   );

   always_comb begin
      picked = ctl.legal ? (regs_flat[idx] & mask) : '0;
      data   = ctl.hib ? (picked >> BYTE_W) : picked;
   end

endmodule

// File: rtl/rfa_write_merge.sv
module rfa_write_merge
   import rfa_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] old_val,
   input  logic [XLEN-1:0] wr_data,
   input  view_ctl_t       ctl,
   input  logic [XLEN-1:0] fld_mask,
   output logic [XLEN-1:0] new_val
);

   logic [XLEN-1:0] aligned;
   logic [XLEN-1:0] kept;

   always_comb begin
      aligned = ctl.hib ? (wr_data << BYTE_W) : wr_data;
      kept    = ctl.zero_rest ? '0 : (old_val & ~fld_mask);
      new_val = kept | (aligned & fld_mask);
   end

endmodule

// File: rtl/rfa_regfile.sv
module rfa_regfile
   import rfa_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter int NUM_REGS = 16,
   parameter int HB_REGS  = 4,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [VIEW_W-1:0] wr_view,
   input  logic [XLEN-1:0]   wr_data,
   output logic              wr_reject,
   input  logic [IDX_W-1:0]  ra_idx,
   input  logic [VIEW_W-1:0] ra_view,
   output logic [XLEN-1:0]   ra_data,
   input  logic [IDX_W-1:0]  rb_idx,
   input  logic [VIEW_W-1:0] rb_view,
   output logic [XLEN-1:0]   rb_data
);

   localparam int NUM_RD = 2;

   // elaboration-time parameter checks
   generate
      if (XLEN < LO32_W) begin : g_bad_xlen
         $error("rfa_regfile: XLEN must be at least 32");
      end
      if (NUM_REGS < 2) begin : g_bad_regs
         $error("rfa_regfile: NUM_REGS must be at least 2");
      end
      if (HB_REGS > NUM_REGS) begin : g_bad_hb
         $error("rfa_regfile: HB_REGS exceeds NUM_REGS");
      end
   endgenerate

   // storage
   logic [XLEN-1:0]                regs [NUM_REGS];
   logic [NUM_REGS-1:0][XLEN-1:0]  regs_flat;

   always_comb begin
      for (int i = 0; i < NUM_REGS; i++) regs_flat[i] = regs[i];
   end

   // write path
   view_ctl_t       wr_ctl;
   logic [XLEN-1:0] wr_mask;
   logic [XLEN-1:0] wr_old;
   logic [XLEN-1:0] wr_new;
   logic            wr_take;
   logic            wr_refused;

   rfa_view_decode #(
      .XLEN     (XLEN),
      .NUM_REGS (NUM_REGS),
      .HB_REGS  (HB_REGS)
   ) u_wr_dec (
      .idx      (wr_idx),
      .view     (wr_view),
      .ctl      (wr_ctl),
      .fld_mask (wr_mask)
   );

   assign wr_old     = wr_ctl.legal ? regs_flat[wr_idx] : '0;
   assign wr_take    = wr_en & wr_ctl.legal;
   assign wr_refused = wr_en & ~wr_ctl.legal;

   rfa_write_merge #(
      .XLEN (XLEN)
   ) u_merge (
      .old_val  (wr_old),
      .wr_data  (wr_data),
      .ctl      (wr_ctl),
      .fld_mask (wr_mask),
      .new_val  (wr_new)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      end else if (wr_take) begin
         regs[wr_idx] <= wr_new;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_reject <= 1'b0;
      else        wr_reject <= wr_refused;
   end

   // read ports
   logic [IDX_W-1:0]  rd_idx  [NUM_RD];
   logic [VIEW_W-1:0] rd_view [NUM_RD];
   logic [XLEN-1:0]   rd_data [NUM_RD];

   assign rd_idx[0]  = ra_idx;
   assign rd_view[0] = ra_view;
   assign rd_idx[1]  = rb_idx;
   assign rd_view[1] = rb_view;
   assign ra_data    = rd_data[0];
   assign rb_data    = rd_data[1];

   generate
      for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
         rfa_read_port #(
            .XLEN     (XLEN),
            .NUM_REGS (NUM_REGS),
            .HB_REGS  (HB_REGS)
         ) u_rd (
            .regs_flat (regs_flat),
            .idx       (rd_idx[p]),
            .view      (rd_view[p]),
            .data      (rd_data[p])
         );
      end
   endgenerate

   // assertions guarding the write merge and reject logic
   p_hib_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_view == VIEW_HIB && int'(wr_idx) >= HB_REGS) |=> wr_reject);

   p_hib_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_view == VIEW_HIB && int'(wr_idx) >= HB_REGS)
      |=> regs[$past(wr_idx)] == $past(regs[wr_idx]));

   p_code_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_view > VIEW_HIB) |=> wr_reject);

   p_good_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en) |=> !wr_reject);

   p_lo32_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_view == VIEW_LO32 && int'(wr_idx) < NUM_REGS)
      |=> regs[$past(wr_idx)][XLEN-1:LO32_W] == '0);

   p_lo16_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_view == VIEW_LO16 && int'(wr_idx) < NUM_REGS)
      |=> regs[$past(wr_idx)][XLEN-1:LO16_W] == $past(regs[wr_idx][XLEN-1:LO16_W]));

   p_rd_zext_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ra_view == VIEW_LOB || ra_view == VIEW_HIB) |-> ra_data[XLEN-1:BYTE_W] == '0);

   p_rd_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_view == VIEW_HIB && int'(rb_idx) >= HB_REGS) |-> rb_data == '0);

endmodule

// File: tb/tb_rfa_regfile.sv
module tb_rfa_regfile;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [2:0]  wr_view = '0;
   logic [63:0] wr_data = '0;
   logic        wr_reject;
   logic [3:0]  ra_idx = '0;
   logic [2:0]  ra_view = '0;
   logic [63:0] ra_data;
   logic [3:0]  rb_idx = '0;
   logic [2:0]  rb_view = '0;
   logic [63:0] rb_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   rfa_regfile dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_view   (wr_view),
      .wr_data   (wr_data),
      .wr_reject (wr_reject),
      .ra_idx    (ra_idx),
      .ra_view   (ra_view),
      .ra_data   (ra_data),
      .rb_idx    (rb_idx),
      .rb_view   (rb_view),
      .rb_data   (rb_data)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input int idx, input int view, input logic [63:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 4'(idx); wr_view = 3'(view); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      #1;
   endtask

   task automatic rda(input int idx, input int view, output logic [63:0] d);
      ra_idx = 4'(idx); ra_view = 3'(view);
      #1;
      d = ra_data;
   endtask

   task automatic t_reset;
      logic [63:0] d;
      for (int i = 0; i < 16; i++) begin
         rda(i, 0, d);
         chk($sformatf("R1 reg%0d after reset", i), d, 64'h0);
      end
      chk("R6 no reject after reset", {63'h0, wr_reject}, 64'h0);
   endtask

   task automatic t_full;
      logic [63:0] d;
      wr(5, 0, 64'hDEAD_BEEF_0BAD_F00D);
      chk("R6 accepted write no reject", {63'h0, wr_reject}, 64'h0);
      rda(5, 0, d);
      chk("R2 full round trip", d, 64'hDEAD_BEEF_0BAD_F00D);
      wr(12, 0, 64'h8000_0000_0000_0001);
      rda(12, 0, d);
      chk("R2 full round trip reg12", d, 64'h8000_0000_0000_0001);
   endtask

   task automatic t_lo32;
      logic [63:0] d;
      wr(2, 0, 64'hFFFF_FFFF_FFFF_FFFF);
      wr(2, 1, 64'hAAAA_AAAA_1234_5678);
      rda(2, 0, d);
      chk("R4 low32 write clears upper", d, 64'h0000_0000_1234_5678);
      rda(2, 1, d);
      chk("R8 low32 read", d, 64'h0000_0000_1234_5678);
   endtask

   task automatic t_narrow;
      logic [63:0] d;
      wr(9, 0, 64'hAAAA_BBBB_CCCC_DDDD);
      wr(9, 2, 64'hFFFF_FFFF_FFFF_1111);
      rda(9, 0, d);
      chk("R3 low16 write merges", d, 64'hAAAA_BBBB_CCCC_1111);
      wr(9, 3, 64'hFFFF_FFFF_FFFF_FF22);
      rda(9, 0, d);
      chk("R3 low byte write merges", d, 64'hAAAA_BBBB_CCCC_1122);
      rda(9, 3, d);
      chk("R8 low byte read zero-extended", d, 64'h22);
      rda(9, 2, d);
      chk("R8 low16 read zero-extended", d, 64'h1122);
      rda(9, 1, d);
      chk("R8 low32 read zero-extended", d, 64'hCCCC_1122);
   endtask

   task automatic t_hib;
      logic [63:0] d;
      wr(1, 0, 64'h0123_4567_89AB_CDEF);
      wr(1, 4, 64'hFFFF_FFFF_FFFF_FF5A);
      rda(1, 0, d);
      chk("R5 high byte write merges", d, 64'h0123_4567_89AB_5AEF);
      rda(1, 4, d);
      chk("R5 high byte read", d, 64'h5A);
      wr(3, 0, 64'h1111_2222_3333_4444);
      wr(3, 4, 64'h0000_0000_0000_00C3);
      rda(3, 0, d);
      chk("R5 high byte reg3 boundary", d, 64'h1111_2222_3333_C344);
      chk("R6 legal high byte no reject", {63'h0, wr_reject}, 64'h0);
   endtask

   task automatic t_hib_bad;
      logic [63:0] d;
      wr(4, 0, 64'hFEDC_BA98_7654_3210);
      wr(4, 4, 64'h0000_0000_0000_0099);
      chk("R6 reject pulse reg4", {63'h0, wr_reject}, 64'h1);
      @(negedge clk); #1;
      chk("R6 reject lasts one cycle", {63'h0, wr_reject}, 64'h0);
      rda(4, 0, d);
      chk("R6 reg4 unchanged", d, 64'hFEDC_BA98_7654_3210);
      rda(4, 4, d);
      chk("R6 reg4 high byte read zero", d, 64'h0);
      wr(15, 0, 64'h0F0F_0F0F_0F0F_0F0F);
      wr(15, 4, 64'h77);
      chk("R6 reject pulse reg15", {63'h0, wr_reject}, 64'h1);
      rda(15, 0, d);
      chk("R6 reg15 unchanged", d, 64'h0F0F_0F0F_0F0F_0F0F);
   endtask

   task automatic t_bad_code;
      logic [63:0] d;
      wr(0, 0, 64'h5555_6666_7777_8888);
      for (int v = 5; v < 8; v++) begin
         wr(0, v, 64'h0);
         chk($sformatf("R7 code %0d reject", v), {63'h0, wr_reject}, 64'h1);
         rda(0, 0, d);
         chk($sformatf("R7 code %0d reg0 unchanged", v), d, 64'h5555_6666_7777_8888);
         rda(0, v, d);
         chk($sformatf("R7 code %0d read zero", v), d, 64'h0);
      end
   endtask

   task automatic t_rdw;
      logic [63:0] d;
      wr(7, 0, 64'h1111_1111_1111_1111);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 4'd7; wr_view = 3'd0; wr_data = 64'h2222_2222_2222_2222;
      rda(7, 0, d);
      chk("R9 same-cycle read sees old", d, 64'h1111_1111_1111_1111);
      @(negedge clk);
      wr_en = 1'b0;
      #1;
      chk("R9 next cycle sees new", ra_data, 64'h2222_2222_2222_2222);
   endtask

   task automatic t_ports;
      wr(6, 0, 64'hCAFE_0000_0000_BABE);
      ra_idx = 4'd6; ra_view = 3'd2;
      rb_idx = 4'd1; rb_view = 3'd4;
      #1;
      chk("R10 port A low16 reg6", ra_data, 64'hBABE);
      chk("R10 port B high byte reg1", rb_data, 64'h5A);
      ra_idx = 4'd9; ra_view = 3'd0;
      rb_idx = 4'd6; rb_view = 3'd0;
      #1;
      chk("R10 port A full reg9", ra_data, 64'hAAAA_BBBB_CCCC_1122);
      chk("R10 port B full reg6", rb_data, 64'hCAFE_0000_0000_BABE);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_full();
      t_lo32();
      t_narrow();
      t_hib();
      t_hib_bad();
      t_bad_code();
      t_rdw();
      t_ports();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule